// File: doc/BRIEF.md
# Level Interrupt Combiner with Set/Clear Enable Mask

This block collects eight interrupt sources into one request line. The upper four sources are level-sensitive hardware request inputs. Bit 4 carries the push-button request and bits 7 to 5 are spare inputs. The lower four sources are software interrupts that a processor raises by writing to a register. Each source has an enable bit. The block ANDs the raw source levels with the enable mask to form a masked status. Whenever any masked bit is set, the block raises a single registered interrupt output.

All access goes through an APB slave port. Software never writes the enable mask directly. One register location sets enable bits wherever the written value has a 1, and another location clears them. A read of the set location returns the current mask. The software interrupt register also works bit by bit: a nonzero write ORs its ones into the register, and a write whose low four bits are all zero clears every software interrupt. Widths and source counts are parameters, and an elaboration check rejects combinations that do not fit the data bus.

Top module: `lvl_irq_combiner`

## Requirements
- R1: After reset the enable mask and the software interrupts are all zero, `irq_o` is 0, and reads of word offsets 0x00, 0x08 and 0x10 return 0.
- R2: A read of offset 0x04 returns the raw status. Bits [7:4] are the current levels of `hw_req[3:0]`, with bit 4 being the push-button request. Bits [3:0] are the software interrupts. All other bits are 0.
- R3: A read of offset 0x00 returns the masked status, which is the bitwise AND of the raw status and the enable mask.
- R4: An APB write to offset 0x08 sets each enable bit whose written data bit is 1 and leaves the other enable bits unchanged. A read of 0x08 returns the enable mask in bits [7:0].
- R5: An APB write to offset 0x0C clears each enable bit whose written data bit is 1 and leaves the other enable bits unchanged.
- R6: An APB write to offset 0x10 whose data bits [3:0] are not all zero ORs those four bits into the software interrupt register.
- R7: An APB write to offset 0x10 whose data bits [3:0] are all zero clears all four software interrupts. A read of 0x10 returns the software interrupts in bits [3:0].
- R8: `irq_o` is a register. In each cycle it equals the OR of all masked status bits as they stood in the previous cycle.
- R9: Reads of offset 0x0C, and of any offset other than 0x00 to 0x10, return 0. Writes to 0x00, 0x04 or unmapped offsets change neither the mask nor the software interrupts.
- R10: A write takes effect only in the APB access phase, when `psel`, `penable` and `pwrite` are all high. A setup phase that is not followed by an access phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access-phase strobe |
| pwrite | input | 1 | APB direction, 1 for a write |
| paddr | input | ADDR_W (12) | Byte address. Bits [1:0] are ignored |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data. Driven while `psel` is high and `pwrite` is low, otherwise 0 |
| hw_req | input | NUM_HW (4) | Level-sensitive hardware requests, 1 = active |
| irq_o | output | 1 | Registered combined interrupt request, 1 = asserted |

## Verification
The assertions assume that `hw_req` is synchronous to `pclk`, so a level seen at one edge is the level the output register captured. They also assume APB transfers are well formed: `penable` rises only in the cycle after a setup phase with `psel` high, and the address and data hold steady across the two phases. The bench drives every input on the falling clock edge. It issues each write as a full setup-then-access pair, except for one deliberate setup-only cycle that tests R10. Hardware request levels change only between transfers, so the reference model and the design see the same levels at every rising edge.

// File: rtl/lic_pkg.sv
package lic_pkg;

   // word indices (byte offset / 4) of the register locations
   localparam int unsigned WIDX_MASKED = 0;
   localparam int unsigned WIDX_RAW    = 1;
   localparam int unsigned WIDX_ENSET  = 2;
   localparam int unsigned WIDX_ENCLR  = 3;
   localparam int unsigned WIDX_SOFT   = 4;

   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_MASKED = 3'd1,
      SEL_RAW    = 3'd2,
      SEL_ENSET  = 3'd3,
      SEL_ENCLR  = 3'd4,
      SEL_SOFT   = 3'd5
   } lic_sel_e;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
   import lic_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
)(
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output lic_sel_e          sel,
   output logic              wr_stb,
   output logic              rd_act
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              unused_lsb;

   assign word       = paddr[ADDR_W-1:2];
   assign unused_lsb = ^paddr[1:0];

   always_comb begin
      if      (word == WORD_W'(WIDX_MASKED)) sel = SEL_MASKED;
      else if (word == WORD_W'(WIDX_RAW))    sel = SEL_RAW;
      else if (word == WORD_W'(WIDX_ENSET))  sel = SEL_ENSET;
      else if (word == WORD_W'(WIDX_ENCLR))  sel = SEL_ENCLR;
      else if (word == WORD_W'(WIDX_SOFT))   sel = SEL_SOFT;
      else                                   sel = SEL_NONE;
   end

   assign wr_stb = psel & penable & pwrite;
   assign rd_act = psel & ~pwrite;

endmodule

// File: rtl/lic_enable_bank.sv
module lic_enable_bank #(
   parameter int unsigned N = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] en_q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set_stb && wdata[i])
            bit_q <= 1'b1;
         else if (clr_stb && wdata[i])
            bit_q <= 1'b0;
      end
      assign en_q[i] = bit_q;
   end

endmodule

// File: rtl/lic_soft_bank.sv
module lic_soft_bank #(
   parameter int unsigned N = 4
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] soft_q
);

   logic clear_all;
   assign clear_all = (wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         soft_q <= '0;
      else if (wr_stb) begin
         if (clear_all)
            soft_q <= '0;
         else
            soft_q <= soft_q | wdata;
      end
   end

endmodule

// File: rtl/lic_irq_reg.sv
module lic_irq_reg #(
   parameter int unsigned N = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   input  logic [N-1:0] en,
   output logic [N-1:0] masked,
   output logic         irq_o
);

   assign masked = raw & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else
         irq_o <= |masked;
   end

endmodule

// File: rtl/lvl_irq_combiner.sv
module lvl_irq_combiner
   import lic_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_HW = 4,
   parameter int unsigned NUM_SW = 4
)(
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic [NUM_HW-1:0] hw_req,
   output logic              irq_o
);

   localparam int unsigned NUM_SRC = NUM_HW + NUM_SW;

   // elaboration-time parameter checks
   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("lvl_irq_combiner: NUM_HW+NUM_SW exceeds DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("lvl_irq_combiner: ADDR_W must cover offset 0x10");
   end
   if (NUM_HW == 0 || NUM_SW == 0) begin : g_bad_count
      $error("lvl_irq_combiner: source counts must be nonzero");
   end

   lic_sel_e             sel;
   logic                 wr_stb;
   logic                 rd_act;
   logic [NUM_SRC-1:0]   en_q;
   logic [NUM_SW-1:0]    soft_q;
   logic [NUM_SRC-1:0]   raw;
   logic [NUM_SRC-1:0]   masked;

   lic_decode #(.ADDR_W(ADDR_W)) u_decode (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .sel     (sel),
      .wr_stb  (wr_stb),
      .rd_act  (rd_act)
   );

   lic_enable_bank #(.N(NUM_SRC)) u_enable (
      .clk     (pclk),
      .rst_n   (presetn),
      .set_stb (wr_stb && (sel == SEL_ENSET)),
      .clr_stb (wr_stb && (sel == SEL_ENCLR)),
      .wdata   (pwdata[NUM_SRC-1:0]),
      .en_q    (en_q)
   );

   lic_soft_bank #(.N(NUM_SW)) u_soft (
      .clk     (pclk),
      .rst_n   (presetn),
      .wr_stb  (wr_stb && (sel == SEL_SOFT)),
      .wdata   (pwdata[NUM_SW-1:0]),
      .soft_q  (soft_q)
   );

   assign raw = {hw_req, soft_q};

   lic_irq_reg #(.N(NUM_SRC)) u_irq (
      .clk     (pclk),
      .rst_n   (presetn),
      .raw     (raw),
      .en      (en_q),
      .masked  (masked),
      .irq_o   (irq_o)
   );

   if (NUM_SRC < DATA_W) begin : g_unused_hi
      logic unused_wdata;
      assign unused_wdata = ^pwdata[DATA_W-1:NUM_SRC];
   end

   always_comb begin
      prdata = '0;
      if (rd_act) begin
         case (sel)
            SEL_MASKED: prdata = DATA_W'(masked);
            SEL_RAW:    prdata = DATA_W'(raw);
            SEL_ENSET:  prdata = DATA_W'(en_q);
            SEL_SOFT:   prdata = DATA_W'(soft_q);
            default:    prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_HW = 4,
   parameter int unsigned NUM_SW = 4
)(
   input logic                     pclk,
   input logic                     presetn,
   input logic                     psel,
   input logic                     penable,
   input logic                     pwrite,
   input logic [ADDR_W-1:0]        paddr,
   input logic [DATA_W-1:0]        pwdata,
   input logic [DATA_W-1:0]        prdata,
   input logic [NUM_HW-1:0]        hw_req,
   input logic                     irq_o,
   input logic [NUM_HW+NUM_SW-1:0] en_q,
   input logic [NUM_SW-1:0]        soft_q
);

   localparam int unsigned NS = NUM_HW + NUM_SW;
   localparam int unsigned WW = ADDR_W - 2;

   logic          wr, rd;
   logic [WW-1:0] idx;
   logic [NS-1:0] raw_v;
   logic [NS-1:0] wbits;

   assign wr    = psel && penable && pwrite;
   assign rd    = psel && !pwrite;
   assign idx   = paddr[ADDR_W-1:2];
   assign raw_v = {hw_req, soft_q};
   assign wbits = pwdata[NS-1:0];

   // R2
   a_r2_raw_read: assert property (@(posedge pclk) disable iff (!presetn)
      (rd && idx == WW'(1)) |-> prdata == DATA_W'(raw_v));

   // R3
   a_r3_masked_read: assert property (@(posedge pclk) disable iff (!presetn)
      (rd && idx == WW'(0)) |-> prdata == DATA_W'(raw_v & en_q));

   // R4
   a_r4_set_raises: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && idx == WW'(2)) |=> en_q == ($past(en_q) | $past(wbits)));

   // R5
   a_r5_clear_drops: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && idx == WW'(3)) |=> en_q == ($past(en_q) & ~$past(wbits)));

   // R6
   a_r6_soft_or: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && idx == WW'(4) && pwdata[NUM_SW-1:0] != '0)
      |=> soft_q == ($past(soft_q) | $past(pwdata[NUM_SW-1:0])));

   // R7
   a_r7_soft_zero_clears: assert property (@(posedge pclk) disable iff (!presetn)
      (wr && idx == WW'(4) && pwdata[NUM_SW-1:0] == '0) |=> soft_q == '0);

   // R8
   a_r8_irq_registered: assert property (@(posedge pclk) disable iff (!presetn)
      1'b1 |=> irq_o == $past(|(raw_v & en_q)));

   // R9 / R10
   a_r9_mask_stable: assert property (@(posedge pclk) disable iff (!presetn)
      !(wr && (idx == WW'(2) || idx == WW'(3))) |=> $stable(en_q));

   a_r10_soft_stable: assert property (@(posedge pclk) disable iff (!presetn)
      !(wr && idx == WW'(4)) |=> $stable(soft_q));

   // R9
   a_r9_clear_reads_zero: assert property (@(posedge pclk) disable iff (!presetn)
      (rd && idx == WW'(3)) |-> prdata == '0);

endmodule

bind lvl_irq_combiner lic_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NUM_HW (NUM_HW),
   .NUM_SW (NUM_SW)
) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .pwdata  (pwdata),
   .prdata  (prdata),
   .hw_req  (hw_req),
   .irq_o   (irq_o),
   .en_q    (en_q),
   .soft_q  (soft_q)
);

// File: tb/lvl_irq_combiner_test.sv
module lvl_irq_combiner_test;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [3:0]  hw_req = '0;
   logic        irq_o;

   int vectors = 0;
   int misses  = 0;

   // reference model state
   int en_m   = 0;
   int soft_m = 0;
   int irq_m  = 0;

   always #2 pclk = ~pclk;

   lvl_irq_combiner uut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .hw_req(hw_req), .irq_o(irq_o)
   );

   function automatic int raw_m();
      return (int'(hw_req) << 4) | soft_m;
   endfunction

   function automatic int read_m(int addr);
      case (addr)
         'h00: return raw_m() & en_m;
         'h04: return raw_m();
         'h08: return en_m;
         'h10: return soft_m;
         default: return 0;
      endcase
   endfunction

   // model update at each rising edge
   always @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         en_m = 0; soft_m = 0; irq_m = 0;
      end else begin
         irq_m = ((raw_m() & en_m) != 0) ? 1 : 0;
         if (psel && penable && pwrite) begin
            case (int'(paddr))
               'h08: en_m = en_m | int'(pwdata[7:0]);
               'h0C: en_m = en_m & ~int'(pwdata[7:0]);
               'h10: soft_m = (pwdata[3:0] == 4'd0) ? 0 : (soft_m | int'(pwdata[3:0]));
               default: ;
            endcase
         end
      end
   end

   // R8: per-clock comparison of the interrupt output
   always @(negedge pclk) begin
      if (presetn) begin
         vectors++;
         if (int'(irq_o) != irq_m) begin
            misses++;
            $display("FAIL R8 irq_o actual=%0d expected=%0d", irq_o, irq_m);
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic apb_write(int addr, int data);
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0;
      paddr = 12'(addr); pwdata = 32'(data);
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_read(int addr, int exp, string tag);
      @(negedge pclk);
      psel = 1; pwrite = 0; penable = 0; paddr = 12'(addr);
      @(negedge pclk);
      penable = 1;
      #1;
      check(tag, int'(prdata), exp);
      @(negedge pclk);
      psel = 0; penable = 0;
   endtask

   task automatic read_model(int addr, string tag);
      apb_read(addr, read_m(addr), tag);
   endtask

   initial begin
      repeat (100000) @(posedge pclk);
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1;
      @(negedge pclk);
      // R1: reset state
      check("R1 irq after reset", int'(irq_o), 0);
      apb_read('h00, 0, "R1 masked");
      apb_read('h08, 0, "R1 enable");
      apb_read('h10, 0, "R1 soft");

      // R2 / R3: push-button request with mask closed
      hw_req = 4'b0001;
      apb_read('h04, 'h10, "R2 raw push-button bit 4");
      apb_read('h00, 'h00, "R3 masked with no enable");

      // R4: set enable bits
      apb_write('h08, 'h10);
      apb_read('h08, 'h10, "R4 enable after set");
      apb_read('h00, 'h10, "R3 masked after enable");
      apb_write('h08, 'h01);
      apb_read('h08, 'h11, "R4 zero bits left unchanged");
      apb_write('h08, 'h00);
      apb_read('h08, 'h11, "R4 set with zero");

      // R6: software interrupts OR in
      apb_write('h10, 'h5);
      apb_read('h10, 'h5, "R6 soft after first write");
      apb_write('h10, 'h2);
      apb_read('h10, 'h7, "R6 soft OR accumulate");
      apb_read('h04, 'h17, "R2 raw with soft");
      apb_read('h00, 'h11, "R3 masked with soft");

      // R5: clear enable bits
      apb_write('h0C, 'h10);
      apb_read('h08, 'h01, "R5 enable after clear");
      apb_write('h0C, 'h00);
      apb_read('h08, 'h01, "R5 clear with zero");

      // R7: zero write clears soft, upper bits do not count
      apb_write('h10, 'h0);
      apb_read('h10, 'h0, "R7 soft cleared");
      apb_write('h10, 'hA);
      apb_write('h10, 'h30);
      apb_read('h10, 'h0, "R7 soft cleared by low-nibble zero");

      // R9: write-only and unmapped reads, writes to read-only locations
      apb_write('h08, 'hFF);
      apb_write('h10, 'h3);
      apb_read('h0C, 0, "R9 clear location reads zero");
      apb_read('h14, 0, "R9 unmapped reads zero");
      apb_write('h00, 'h00);
      apb_write('h04, 'h00);
      apb_write('h0C0, 'hFF);
      apb_read('h08, 'hFF, "R9 enable untouched by other writes");
      apb_read('h10, 'h3, "R9 soft untouched by other writes");

      // R10: setup phase only
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0; paddr = 12'h0C; pwdata = 32'hFF;
      @(negedge pclk);
      psel = 0; pwrite = 0;
      apb_read('h08, 'hFF, "R10 setup-only leaves enable");

      // R3 / R8: sweep hardware levels against partial masks
      apb_write('h10, 'h0);
      apb_write('h0C, 'hFF);
      apb_write('h08, 'h60);
      for (int v = 0; v < 16; v++) begin
         hw_req = 4'(v);
         read_model('h00, "R3 masked sweep");
         read_model('h04, "R2 raw sweep");
      end
      hw_req = 4'b0000;
      apb_write('h10, 'h8);
      apb_write('h08, 'h08);
      read_model('h00, "R3 soft-only interrupt");
      apb_write('h0C, 'h08);
      read_model('h00, "R3 soft masked off");

      repeat (4) @(negedge pclk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule